// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home node for a group of memory blocks in a shared-memory machine whose caches keep coherence through a directory, not through a shared bus that every cache watches. For each block it holds one of three states and a bit vector with one bit per cache. Caches send it read misses, write misses, upgrade requests (a write hit on a shared copy) and write-backs. The home answers with data replies, invalidations sent to several caches at once, or a recall to the single owner. It waits for every targeted cache to acknowledge before it finishes the transaction.

Only one transaction is open at a time. A request that arrives while one is open is refused with a busy reply, and the cache must retry it. The network, the caches and the memory array are outside the block and appear only as single-cycle pulse ports. This version carries control only: it reports which block memory must read or write and leaves the data path to its neighbours.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is unowned (state U, empty sharer vector), and `msg_valid`, `mem_rd_en`, `mem_wr_en` and `nack_valid` are all 0.
- R2: A read miss (kind 0) on a U block sends a data reply (message kind 1) to the requester alone in the cycle after acceptance, together with a memory read. The block becomes S with only the requester recorded.
- R3: A write miss (kind 1) or upgrade (kind 2) on a U block sends a data reply with a memory read. The block becomes E owned by the requester.
- R4: A read miss on an S block sends a data reply with a memory read and adds the requester to the sharers. The state stays S.
- R5: A write miss or upgrade on an S block sends one invalidate (kind 2) addressed to every other sharer and never to the requester. Once all of them have acknowledged, it sends a data reply with a memory read if the request was a miss or the requester held no copy. The block becomes E owned by the requester. If there are no other sharers, this happens at once.
- R6: A read miss on an E block from a cache that is not the owner sends a recall (kind 3) to the owner. After the owner acknowledges, memory is written, the requester gets a data reply, and the block becomes S with both caches recorded.
- R7: A write miss or upgrade on an E block from a cache that is not the owner recalls the block from the owner. After the acknowledgement, the requester gets a data reply with no memory write, and the block stays E with the requester as the new owner.
- R8: A write-back (kind 3) from the owner of an E block writes memory and leaves the block U with no sharers.
- R9: A write-back on a U or S block, a write-back from a cache that is not the owner, and any other request from the current owner of an E block all produce no message and no memory access, and leave the entry unchanged.
- R10: While a transaction is open, any request is answered one cycle later with `nack_valid` and `nack_dst` set to its source. It sends no message and changes no entry.
- R11: An acknowledgement from a cache that is not awaited, or one that arrives when no transaction is open, has no effect. The transaction completes only on the acknowledgement from the last awaited cache.
- R12: Every entry written as E has exactly one sharer bit set, and every entry written as U has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 write-back |
| req_src | input | log2(NUM_CACHES) | Requesting cache |
| req_blk | input | log2(NUM_BLOCKS) | Block index |
| ack_valid | input | 1 | Acknowledgement present |
| ack_src | input | log2(NUM_CACHES) | Acknowledging cache |
| msg_valid | output | 1 | Message to caches this cycle |
| msg_kind | output | 2 | 1 data reply, 2 invalidate, 3 recall |
| msg_dst | output | NUM_CACHES | Destination caches, one bit each |
| msg_blk | output | log2(NUM_BLOCKS) | Block the message concerns |
| mem_rd_en | output | 1 | Memory supplies the block |
| mem_wr_en | output | 1 | Memory takes returned data |
| mem_blk | output | log2(NUM_BLOCKS) | Block for the memory access |
| nack_valid | output | 1 | Busy reply to a refused request |
| nack_dst | output | log2(NUM_CACHES) | Cache receiving the busy reply |

## Verification
The bench builds the block with four caches and four blocks. With four caches, an upgrade can find up to three other sharers and a recall can target any owner. Four blocks keep independent histories side by side, so a stale index would show up. At this size a few hundred mixed requests reach every pairing of state, request kind and ownership. During every open transaction the bench also injects a refused request and an acknowledgement from a cache that is not awaited.

// File: rtl/coh_dir_pkg.sv
// Shared types for the home-node directory.
// Assumes the encodings below are the ones the caches and network use.
package coh_dir_pkg;

    // Directory state per block; value 3 is never stored.
    typedef enum logic [1:0] {
        DIR_U = 2'd0,
        DIR_S = 2'd1,
        DIR_E = 2'd2
    } dir_state_e;

    // Request kinds arriving from caches.
    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_WR  = 2'd1,
        REQ_UPG = 2'd2,
        REQ_WB  = 2'd3
    } req_kind_e;

    // Message kinds sent to caches.
    typedef enum logic [1:0] {
        MSG_NONE   = 2'd0,
        MSG_DATA   = 2'd1,
        MSG_INV    = 2'd2,
        MSG_RECALL = 2'd3
    } msg_kind_e;

endpackage

// File: rtl/coh_dir_store.sv
// Directory entry storage: one state and one sharer vector per block.
// One combinational read port and one write port.
// Assumes NUM_BLOCKS is a power of two so every index is in range.
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BW-1:0]         rd_blk,
    output dir_state_e            rd_state,
    output logic [NUM_CACHES-1:0] rd_vec,
    input  logic                  wr_en,
    input  logic [BW-1:0]         wr_blk,
    input  dir_state_e            wr_state,
    input  logic [NUM_CACHES-1:0] wr_vec
);

    dir_state_e            st_q  [NUM_BLOCKS];
    logic [NUM_CACHES-1:0] vec_q [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
        // Holds one entry; clears it to unowned on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= DIR_U;
                vec_q[g] <= '0;
            end else if (wr_en && (wr_blk == BW'(g))) begin
                st_q[g]  <= wr_state;
                vec_q[g] <= wr_vec;
            end
        end
    end

    // Read port for the block being requested.
    assign rd_state = st_q[rd_blk];
    assign rd_vec   = vec_q[rd_blk];

    // R12: an exclusive entry always names exactly one cache.
    a_r12_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DIR_E) |-> $onehot(wr_vec));

    // R12: an unowned entry carries no sharers.
    a_r12_unowned_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DIR_U) |-> (wr_vec == '0));

endmodule

// File: rtl/coh_dir_decide.sv
// Transition logic for an accepted request, purely combinational.
// Gives the message to send now, the entry update to make now, and,
// for requests that must wait for acknowledgements, the set of caches
// to wait on plus the actions and entry value to apply on completion.
module coh_dir_decide
    import coh_dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    localparam int IW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
    input  dir_state_e            cur_state,
    input  logic [NUM_CACHES-1:0] cur_vec,
    input  req_kind_e             kind,
    input  logic [IW-1:0]         src,
    output msg_kind_e             imm_kind,
    output logic [NUM_CACHES-1:0] imm_vec,
    output logic                  imm_mem_rd,
    output logic                  imm_mem_wr,
    output logic                  upd_en,
    output dir_state_e            upd_state,
    output logic [NUM_CACHES-1:0] upd_vec,
    output logic [NUM_CACHES-1:0] wait_vec,
    output logic                  fin_data,
    output logic                  fin_mem_rd,
    output logic                  fin_mem_wr,
    output dir_state_e            fin_state,
    output logic [NUM_CACHES-1:0] fin_vec
);

    logic [NUM_CACHES-1:0] src_bit;
    logic [NUM_CACHES-1:0] others;
    logic                  is_owner;
    logic                  need_data;

    // Requester as a one-hot vector and the sharers other than it.
    assign src_bit   = {{(NUM_CACHES-1){1'b0}}, 1'b1} << src;
    assign others    = cur_vec & ~src_bit;
    assign is_owner  = (cur_vec == src_bit);
    assign need_data = (kind == REQ_WR) || !cur_vec[src];

    // Chooses actions from the current entry and the request kind.
    always_comb begin
        imm_kind   = MSG_NONE;
        imm_vec    = '0;
        imm_mem_rd = 1'b0;
        imm_mem_wr = 1'b0;
        upd_en     = 1'b0;
        upd_state  = DIR_U;
        upd_vec    = '0;
        wait_vec   = '0;
        fin_data   = 1'b0;
        fin_mem_rd = 1'b0;
        fin_mem_wr = 1'b0;
        fin_state  = DIR_U;
        fin_vec    = '0;
        case (cur_state)
            DIR_U: begin
                if (kind != REQ_WB) begin
                    imm_kind   = MSG_DATA;
                    imm_vec    = src_bit;
                    imm_mem_rd = 1'b1;
                    upd_en     = 1'b1;
                    upd_state  = (kind == REQ_RD) ? DIR_S : DIR_E;
                    upd_vec    = src_bit;
                end
            end
            DIR_S: begin
                if (kind == REQ_RD) begin
                    imm_kind   = MSG_DATA;
                    imm_vec    = src_bit;
                    imm_mem_rd = 1'b1;
                    upd_en     = 1'b1;
                    upd_state  = DIR_S;
                    upd_vec    = cur_vec | src_bit;
                end else if (kind != REQ_WB) begin
                    if (others == '0) begin
                        if (need_data) begin
                            imm_kind   = MSG_DATA;
                            imm_vec    = src_bit;
                            imm_mem_rd = 1'b1;
                        end
                        upd_en    = 1'b1;
                        upd_state = DIR_E;
                        upd_vec   = src_bit;
                    end else begin
                        imm_kind   = MSG_INV;
                        imm_vec    = others;
                        wait_vec   = others;
                        fin_data   = need_data;
                        fin_mem_rd = need_data;
                        fin_state  = DIR_E;
                        fin_vec    = src_bit;
                    end
                end
            end
            DIR_E: begin
                if (is_owner) begin
                    if (kind == REQ_WB) begin
                        imm_mem_wr = 1'b1;
                        upd_en     = 1'b1;
                        upd_state  = DIR_U;
                        upd_vec    = '0;
                    end
                end else if (kind != REQ_WB) begin
                    imm_kind   = MSG_RECALL;
                    imm_vec    = cur_vec;
                    wait_vec   = cur_vec;
                    fin_data   = 1'b1;
                    fin_mem_wr = (kind == REQ_RD);
                    fin_state  = (kind == REQ_RD) ? DIR_S : DIR_E;
                    fin_vec    = (kind == REQ_RD) ? (cur_vec | src_bit) : src_bit;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_ack_tracker.sv
// Records which caches still owe an acknowledgement for the open
// transaction. Signals completion in the cycle the last one arrives.
// Acknowledgements from caches not awaited are dropped.
module coh_ack_tracker #(
    parameter int NUM_CACHES = 4,
    localparam int IW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NUM_CACHES-1:0] load_vec,
    input  logic                  ack_valid,
    input  logic [IW-1:0]         ack_src,
    output logic                  busy,
    output logic                  done
);

    logic [NUM_CACHES-1:0] pending_q;
    logic [NUM_CACHES-1:0] ack_bit;
    logic [NUM_CACHES-1:0] remain;
    logic                  hit;

    // Decodes the acknowledgement against the awaited set.
    assign ack_bit = {{(NUM_CACHES-1){1'b0}}, 1'b1} << ack_src;
    assign hit     = ack_valid && pending_q[ack_src];
    assign remain  = pending_q & ~ack_bit;
    assign busy    = (pending_q != '0);
    assign done    = hit && (remain == '0);

    // Loads the awaited set at start and clears bits as acks arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (load) begin
            pending_q <= load_vec;
        end else if (hit) begin
            pending_q <= remain;
        end
    end

    // R11: without a new start, the awaited set only shrinks.
    a_r11_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pending_q & ~$past(pending_q)) == '0));

    // R11: an ack from a cache not awaited leaves the set as it was.
    a_r11_stray_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ack_valid && !pending_q[ack_src]) |=> (pending_q == $past(pending_q)));

endmodule

// File: rtl/coh_home_dir.sv
// Home-node directory controller. Accepts one request at a time,
// turns it into messages and memory pulses one cycle later, waits
// for acknowledgements where needed, and refuses requests while busy.
// Assumes the caches retry refused requests and that each targeted
// cache acknowledges exactly once.
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    localparam int IW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [IW-1:0]         req_src,
    input  logic [BW-1:0]         req_blk,
    input  logic                  ack_valid,
    input  logic [IW-1:0]         ack_src,
    output logic                  msg_valid,
    output logic [1:0]            msg_kind,
    output logic [NUM_CACHES-1:0] msg_dst,
    output logic [BW-1:0]         msg_blk,
    output logic                  mem_rd_en,
    output logic                  mem_wr_en,
    output logic [BW-1:0]         mem_blk,
    output logic                  nack_valid,
    output logic [IW-1:0]         nack_dst
);

    dir_state_e            rd_state;
    logic [NUM_CACHES-1:0] rd_vec;

    msg_kind_e             imm_kind;
    logic [NUM_CACHES-1:0] imm_vec;
    logic                  imm_mem_rd;
    logic                  imm_mem_wr;
    logic                  upd_en;
    dir_state_e            upd_state;
    logic [NUM_CACHES-1:0] upd_vec;
    logic [NUM_CACHES-1:0] wait_vec;
    logic                  fin_data;
    logic                  fin_mem_rd;
    logic                  fin_mem_wr;
    dir_state_e            fin_state;
    logic [NUM_CACHES-1:0] fin_vec;

    logic                  busy;
    logic                  done;
    logic                  accept;
    logic                  start;

    logic                  wr_en;
    logic [BW-1:0]         wr_blk;
    dir_state_e            wr_state;
    logic [NUM_CACHES-1:0] wr_vec;

    logic [BW-1:0]         txn_blk_q;
    logic [IW-1:0]         txn_src_q;
    logic                  txn_data_q;
    logic                  txn_mem_rd_q;
    logic                  txn_mem_wr_q;
    dir_state_e            txn_state_q;
    logic [NUM_CACHES-1:0] txn_vec_q;
    msg_kind_e             msg_kind_q;

    coh_dir_store #(
        .NUM_CACHES(NUM_CACHES),
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_blk  (req_blk),
        .rd_state(rd_state),
        .rd_vec  (rd_vec),
        .wr_en   (wr_en),
        .wr_blk  (wr_blk),
        .wr_state(wr_state),
        .wr_vec  (wr_vec)
    );

    coh_dir_decide #(
        .NUM_CACHES(NUM_CACHES)
    ) u_decide (
        .cur_state (rd_state),
        .cur_vec   (rd_vec),
        .kind      (req_kind_e'(req_kind)),
        .src       (req_src),
        .imm_kind  (imm_kind),
        .imm_vec   (imm_vec),
        .imm_mem_rd(imm_mem_rd),
        .imm_mem_wr(imm_mem_wr),
        .upd_en    (upd_en),
        .upd_state (upd_state),
        .upd_vec   (upd_vec),
        .wait_vec  (wait_vec),
        .fin_data  (fin_data),
        .fin_mem_rd(fin_mem_rd),
        .fin_mem_wr(fin_mem_wr),
        .fin_state (fin_state),
        .fin_vec   (fin_vec)
    );

    coh_ack_tracker #(
        .NUM_CACHES(NUM_CACHES)
    ) u_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_vec (wait_vec),
        .ack_valid(ack_valid),
        .ack_src  (ack_src),
        .busy     (busy),
        .done     (done)
    );

    // Accept only when idle; open a transaction if acks are needed.
    assign accept = req_valid && !busy;
    assign start  = accept && (wait_vec != '0);

    // Entry write: immediate update on accept, deferred update on completion.
    assign wr_en    = (accept && upd_en) || done;
    assign wr_blk   = done ? txn_blk_q   : req_blk;
    assign wr_state = done ? txn_state_q : upd_state;
    assign wr_vec   = done ? txn_vec_q   : upd_vec;

    // Keeps the details of the open transaction until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_blk_q    <= '0;
            txn_src_q    <= '0;
            txn_data_q   <= 1'b0;
            txn_mem_rd_q <= 1'b0;
            txn_mem_wr_q <= 1'b0;
            txn_state_q  <= DIR_U;
            txn_vec_q    <= '0;
        end else if (start) begin
            txn_blk_q    <= req_blk;
            txn_src_q    <= req_src;
            txn_data_q   <= fin_data;
            txn_mem_rd_q <= fin_mem_rd;
            txn_mem_wr_q <= fin_mem_wr;
            txn_state_q  <= fin_state;
            txn_vec_q    <= fin_vec;
        end
    end

    // Registers the outgoing messages, memory pulses and busy replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_kind_q <= MSG_NONE;
            msg_dst    <= '0;
            msg_blk    <= '0;
            mem_rd_en  <= 1'b0;
            mem_wr_en  <= 1'b0;
            mem_blk    <= '0;
            nack_valid <= 1'b0;
            nack_dst   <= '0;
        end else begin
            msg_valid  <= 1'b0;
            mem_rd_en  <= 1'b0;
            mem_wr_en  <= 1'b0;
            nack_valid <= 1'b0;
            if (accept) begin
                msg_valid  <= (imm_kind != MSG_NONE);
                msg_kind_q <= imm_kind;
                msg_dst    <= imm_vec;
                msg_blk    <= req_blk;
                mem_rd_en  <= imm_mem_rd;
                mem_wr_en  <= imm_mem_wr;
                mem_blk    <= req_blk;
            end else if (done) begin
                msg_valid  <= txn_data_q;
                msg_kind_q <= MSG_DATA;
                msg_dst    <= {{(NUM_CACHES-1){1'b0}}, 1'b1} << txn_src_q;
                msg_blk    <= txn_blk_q;
                mem_rd_en  <= txn_mem_rd_q;
                mem_wr_en  <= txn_mem_wr_q;
                mem_blk    <= txn_blk_q;
            end
            if (req_valid && busy) begin
                nack_valid <= 1'b1;
                nack_dst   <= req_src;
            end
        end
    end

    assign msg_kind = msg_kind_q;

    // R5: an invalidation never goes back to the cache that asked.
    a_r5_inv_spares_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind_q == MSG_INV) |-> !msg_dst[txn_src_q]);

    // R2: a data reply and a recall each go to exactly one cache.
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind_q == MSG_DATA || msg_kind_q == MSG_RECALL)) |-> $onehot(msg_dst));

    // R10: a busy reply only follows a request seen the cycle before.
    a_r10_nack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> $past(req_valid));

    // R10: a refused request produces no message and no memory access.
    a_r10_refused_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && !done) |=> (!mem_rd_en && !mem_wr_en && !msg_valid));

endmodule

// File: tb/coh_home_dir_bench.sv
// Self-checking bench: a reference model of the directory, written
// from the requirements, is compared cycle by cycle with the ports.
module coh_home_dir_bench;

    localparam int N  = 4;
    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [1:0] req_src = '0;
    logic [1:0] req_blk = '0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_src = '0;
    logic       msg_valid;
    logic [1:0] msg_kind;
    logic [N-1:0] msg_dst;
    logic [1:0] msg_blk;
    logic       mem_rd_en;
    logic       mem_wr_en;
    logic [1:0] mem_blk;
    logic       nack_valid;
    logic [1:0] nack_dst;

    int n_chk = 0;
    int n_fail = 0;
    int ref_st [NB];
    logic [N-1:0] ref_vec [NB];
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    coh_home_dir #(.NUM_CACHES(N), .NUM_BLOCKS(NB)) u_coh_home_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_blk(msg_blk),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_blk(mem_blk),
        .nack_valid(nack_valid), .nack_dst(nack_dst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Checks every output at once against the expected pulse values.
    task automatic chk_outs(input string tag, input int mv, input int mk, input int md,
                            input int blk, input int rd, input int wr);
        chk({tag, " msg_valid"}, int'(msg_valid), mv);
        if (mv != 0) begin
            chk({tag, " msg_kind"}, int'(msg_kind), mk);
            chk({tag, " msg_dst"}, int'(msg_dst), md);
            chk({tag, " msg_blk"}, int'(msg_blk), blk);
        end
        chk({tag, " mem_rd"}, int'(mem_rd_en), rd);
        chk({tag, " mem_wr"}, int'(mem_wr_en), wr);
        if (rd != 0 || wr != 0) chk({tag, " mem_blk"}, int'(mem_blk), blk);
        chk({tag, " nack"}, int'(nack_valid), 0);
    endtask

    task automatic send_ack(input int src);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_src = 2'(src);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // Issues one request, checks the response, finishes any wait, updates the model.
    task automatic do_req(input int kind, input int src, input int blk);
        int st = ref_st[blk];
        logic [N-1:0] v = ref_vec[blk];
        logic [N-1:0] sb = N'(1) << src;
        logic [N-1:0] oth = v & ~sb;
        bit own = (v == sb);
        bit nd = (kind == 1) || !v[src];
        int ik = 0, ir = 0, iw = 0;
        logic [N-1:0] iv = '0;
        logic [N-1:0] wv = '0;
        int fd = 0, fr = 0, fw = 0, nst = st;
        logic [N-1:0] nvec = v;
        string tag;
        if (st == 0) begin
            tag = (kind == 3) ? "R9" : (kind == 0) ? "R2" : "R3";
            if (kind != 3) begin
                ik = 1; iv = sb; ir = 1; nst = (kind == 0) ? 1 : 2; nvec = sb;
            end
        end else if (st == 1) begin
            tag = (kind == 0) ? "R4" : (kind == 3) ? "R9" : "R5";
            if (kind == 0) begin
                ik = 1; iv = sb; ir = 1; nvec = v | sb;
            end else if (kind != 3) begin
                nst = 2; nvec = sb;
                if (oth == '0) begin
                    if (nd) begin ik = 1; iv = sb; ir = 1; end
                end else begin
                    ik = 2; iv = oth; wv = oth; fd = int'(nd); fr = int'(nd);
                end
            end
        end else begin
            if (own && kind == 3) begin
                tag = "R8"; iw = 1; nst = 0; nvec = '0;
            end else if (own || kind == 3) begin
                tag = "R9";
            end else begin
                tag = (kind == 0) ? "R6" : "R7";
                ik = 3; iv = v; wv = v; fd = 1; fw = int'(kind == 0);
                nst = (kind == 0) ? 1 : 2;
                nvec = (kind == 0) ? (v | sb) : sb;
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = 2'(kind);
        req_src = 2'(src);
        req_blk = 2'(blk);
        @(negedge clk);
        req_valid = 1'b0;
        chk_outs(tag, int'(ik != 0), ik, int'(iv), blk, ir, iw);
        if (wv != '0) begin
            // R10: a request during the wait gets a busy reply.
            @(negedge clk);
            req_valid = 1'b1;
            req_kind = 2'd0;
            req_src = 2'((src + 1) % N);
            req_blk = 2'(blk);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R10 nack_valid", int'(nack_valid), 1);
            chk("R10 nack_dst", int'(nack_dst), (src + 1) % N);
            chk("R10 no msg", int'(msg_valid), 0);
            // R11: an ack from the requester, which is never awaited.
            send_ack(src);
            chk("R11 stray ack msg", int'(msg_valid), 0);
            chk("R11 stray ack mem", int'(mem_rd_en | mem_wr_en), 0);
            for (int i = 0; i < N; i++) begin
                if (wv[i]) begin
                    wv[i] = 1'b0;
                    send_ack(i);
                    if (wv == '0)
                        chk_outs({tag, " completion"}, fd, 1, int'(sb), blk, fr, fw);
                    else
                        chk("R11 partial acks", int'(msg_valid), 0);
                end
            end
        end
        ref_st[blk] = nst;
        ref_vec[blk] = nvec;
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            ref_st[b] = 0;
            ref_vec[b] = '0;
        end
        repeat (4) @(negedge clk);
        chk("R1 msg in reset", int'(msg_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 after reset", 0, 0, 0, 0, 0, 0);
        // R1/R9: write-backs on unowned blocks do nothing.
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < N; s++)
                do_req(3, s, b);
        // R11: an ack with nothing open has no effect.
        send_ack(2);
        chk("R11 idle ack", int'(msg_valid | mem_rd_en | mem_wr_en), 0);
        // Directed sweep through every transition on every block.
        for (int b = 0; b < NB; b++) begin
            for (int s = 0; s < N; s++) do_req(0, s, b);
            do_req(2, (b + 1) % N, b);
            do_req(0, (b + 1) % N, b);
            do_req(0, b % N, b);
            do_req(1, (b + 3) % N, b);
            do_req(2, (b + 2) % N, b);
            do_req(3, (b + 1) % N, b);
            do_req(3, (b + 2) % N, b);
            do_req(1, b % N, b);
            do_req(2, b % N, b);
        end
        // Mixed sweep over kind, source and block.
        for (int it = 0; it < 800; it++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            do_req(int'(seed[17:16]), int'(seed[21:20]), int'(seed[25:24]));
        end
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        report();
        $finish;
    end

endmodule